// File: doc/BRIEF.md
# Channel Synchronization Strobe Router

This block turns synchronization requests into per-channel start and frequency-hop strobes for a bank of receive channels. Requests come from two places. One is a write-only software trigger register: each write names up to four trigger positions and says whether the sync should start the channels, hop their oscillator frequency, or both. The other is an external sync pin. The pin goes through a two-flop synchronizer and a rising-edge detector, and a stored pin-sync configuration gates it. That configuration sets which positions the pin drives, whether the pin starts or hops the channels, and whether only its first edge counts.

The channels are not tied one-to-one to trigger positions. Each channel has a selection field, driven by its own configuration, that picks one of the four positions. This lets all channels follow one position, follow it in pairs, or run independently. Software and pin requests that reach the same output cycle are merged by OR. The outputs are single-cycle registered pulses.

Top module: `chan_sync_ctrl`

## Requirements
- R1: A cycle with `sw_we` high and data bit [p] set (p in 0..3) pulses every channel whose selection field equals p on the clock edge that samples the write. Channels whose selected bit is clear see nothing.
- R2: In a software write, data bit 4 enables the start pulse and data bit 5 enables the hop pulse. The two act independently. A write with both bits clear produces no pulse.
- R3: Channel c follows position `ch_sel[2c+1:2c]`. Any number of channels may share one position.
- R4: A cycle with `pin_cfg_we` high stores data[6:0] as the pin configuration. Bits [3:0] enable trigger positions, bit 4 enables start and bit 5 enables hop. The value holds until the next such write.
- R5: A low-to-high transition of `sync_pin` that is held for at least two clocks makes the pulses on the third clock edge after the pin is first sampled high. A pin held high gives no further pulses.
- R6: With pin configuration bit 6 set, only the first pin edge after the configuration write (or after reset) takes effect, and later edges are ignored. With bit 6 clear, every edge takes effect. Rewriting the configuration re-arms the first-edge latch.
- R7: When a software request and a pin request reach the same output cycle, each channel's start and hop outputs are the OR of the two.
- R8: During and right after reset, all pulses are low and the pin configuration is all zero, so pin edges do nothing until the configuration is written.
- R9: Each request gives pulses that last exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to clk upstream |
| wr_data | input | 7 | Shared write data for both registers |
| sw_we | input | 1 | Software trigger write strobe |
| pin_cfg_we | input | 1 | Pin configuration write strobe |
| sync_pin | input | 1 | Asynchronous external sync pin |
| ch_sel | input | NUM_CH*2 | Per-channel trigger position selection, 2 bits per channel |
| start_pulse | output | NUM_CH | Per-channel start strobe |
| hop_pulse | output | NUM_CH | Per-channel frequency-hop strobe |

## Verification
The bench builds the block with the default four channels and a two-stage pin synchronizer. At this size all four trigger positions can be reached, along with the all-shared, paired, reversed and one-to-one selection patterns. The fixed synchronizer depth gives a known three-edge latency, so the bench checks pin pulses in the exact cycle, makes sure the cycle before is empty, and lines up a software write with a pin request so both land on the same output edge.

// File: rtl/chan_sync_pkg.sv
package chan_sync_pkg;
  localparam int NUM_POS  = 4;
  localparam int POS_W    = 2;
  localparam int DATA_W   = 7;
  localparam int BIT_START = 4;
  localparam int BIT_HOP   = 5;
  localparam int BIT_FIRST = 6;

  typedef struct packed {
    logic               first_only;
    logic               hop_en;
    logic               start_en;
    logic [NUM_POS-1:0] pos_en;
  } pin_cfg_t;

  typedef struct packed {
    logic               start;
    logic               hop;
    logic [NUM_POS-1:0] pos;
  } sync_req_t;
endpackage

// File: rtl/chan_sync_pin_edge.sv
module chan_sync_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic edge_evt
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d[0] = pin_async;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_evt = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/chan_sync_pin_cfg.sv
module chan_sync_pin_cfg
  import chan_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              pin_evt,
  output sync_req_t         pin_req
);
  pin_cfg_t cfg_q, cfg_d;
  logic     fired_q, fired_d;
  logic     evt_ok;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.pos_en     = cfg_data[NUM_POS-1:0];
      cfg_d.start_en   = cfg_data[BIT_START];
      cfg_d.hop_en     = cfg_data[BIT_HOP];
      cfg_d.first_only = cfg_data[BIT_FIRST];
    end
  end

  assign evt_ok = pin_evt & ~(cfg_q.first_only & fired_q);

  always_comb begin
    fired_d = fired_q;
    if (cfg_we) begin
      fired_d = 1'b0;
    end else if (pin_evt && cfg_q.first_only) begin
      fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      fired_q <= fired_d;
    end
  end

  always_comb begin
    pin_req.start = evt_ok & cfg_q.start_en;
    pin_req.hop   = evt_ok & cfg_q.hop_en;
    pin_req.pos   = evt_ok ? cfg_q.pos_en : '0;
  end
endmodule

// File: rtl/chan_sync_route.sv
module chan_sync_route
  import chan_sync_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH*POS_W-1:0] ch_sel,
  input  sync_req_t               sw_req,
  input  sync_req_t               pin_req,
  output logic [NUM_CH-1:0]       start_nxt,
  output logic [NUM_CH-1:0]       hop_nxt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [POS_W-1:0] sel;
    logic             sw_hit;
    logic             pin_hit;
    assign sel          = ch_sel[c*POS_W +: POS_W];
    assign sw_hit       = sw_req.pos[sel];
    assign pin_hit      = pin_req.pos[sel];
    assign start_nxt[c] = (sw_hit & sw_req.start) | (pin_hit & pin_req.start);
    assign hop_nxt[c]   = (sw_hit & sw_req.hop)   | (pin_hit & pin_req.hop);
  end
endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
  import chan_sync_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    sw_we,
  input  logic                    pin_cfg_we,
  input  logic                    sync_pin,
  input  logic [NUM_CH*POS_W-1:0] ch_sel,
  output logic [NUM_CH-1:0]       start_pulse,
  output logic [NUM_CH-1:0]       hop_pulse
);
  logic              pin_evt;
  sync_req_t         pin_req;
  sync_req_t         sw_req;
  logic [NUM_CH-1:0] start_d, hop_d;
  logic [NUM_CH-1:0] start_q, hop_q;

  chan_sync_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_async(sync_pin), .edge_evt(pin_evt)
  );

  chan_sync_pin_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(pin_cfg_we), .cfg_data(wr_data),
    .pin_evt(pin_evt), .pin_req(pin_req)
  );

  always_comb begin
    sw_req.start = sw_we & wr_data[BIT_START];
    sw_req.hop   = sw_we & wr_data[BIT_HOP];
    sw_req.pos   = sw_we ? wr_data[NUM_POS-1:0] : '0;
  end

  chan_sync_route #(.NUM_CH(NUM_CH)) u_route (
    .ch_sel(ch_sel), .sw_req(sw_req), .pin_req(pin_req),
    .start_nxt(start_d), .hop_nxt(hop_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      hop_q   <= '0;
    end else begin
      start_q <= start_d;
      hop_q   <= hop_d;
    end
  end

  assign start_pulse = start_q;
  assign hop_pulse   = hop_q;
endmodule

// File: rtl/chan_sync_ctrl_chk.sv
module chan_sync_ctrl_chk
  import chan_sync_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] wr_data,
  input logic              sw_we,
  input logic              pin_evt,
  input sync_req_t         pin_req,
  input logic [NUM_CH-1:0] start_pulse,
  input logic [NUM_CH-1:0] hop_pulse
);
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|start_pulse) || (|hop_pulse)) |-> ($past(sw_we) || $past(pin_evt))); // R9

  AST_PIN_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |=> !pin_evt); // R5

  AST_SW_ALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && (&wr_data[NUM_POS-1:0]) && wr_data[BIT_START]) |=> (&start_pulse)); // R1

  AST_SW_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !wr_data[BIT_START] && !pin_req.start) |=> (start_pulse == '0)); // R2

  AST_PIN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_evt && pin_req.pos == '0 && !pin_req.start && !pin_req.hop && !sw_we)
      |=> (start_pulse == '0 && hop_pulse == '0)); // R6
endmodule

bind chan_sync_ctrl chan_sync_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .sw_we(sw_we),
  .pin_evt(pin_evt), .pin_req(pin_req),
  .start_pulse(start_pulse), .hop_pulse(hop_pulse)
);

// File: tb/chan_sync_ctrl_tb_top.sv
module chan_sync_ctrl_tb_top;
  localparam int NCH = 4;

  logic           clk;
  logic           rst_n;
  logic [6:0]     wr_data;
  logic           sw_we;
  logic           pin_cfg_we;
  logic           sync_pin;
  logic [7:0]     ch_sel;
  logic [NCH-1:0] start_pulse;
  logic [NCH-1:0] hop_pulse;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  chan_sync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .sw_we(sw_we),
    .pin_cfg_we(pin_cfg_we), .sync_pin(sync_pin), .ch_sel(ch_sel),
    .start_pulse(start_pulse), .hop_pulse(hop_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {ch_sel, wr_data(8b view), exp_start, exp_hop}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hE4, 8'h31, 4'b0001, 4'b0001},
    {8'hE4, 8'h1A, 4'b1010, 4'b0000},
    {8'hE4, 8'h2F, 4'b0000, 4'b1111},
    {8'hAA, 8'h34, 4'b1111, 4'b1111},
    {8'hAA, 8'h3B, 4'b0000, 4'b0000},
    {8'h50, 8'h12, 4'b1100, 4'b0000},
    {8'h50, 8'h0F, 4'b0000, 4'b0000},
    {8'h1B, 8'h19, 4'b1001, 4'b0000}
  };

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic write_pin_cfg(input logic [6:0] d);
    @(negedge clk);
    wr_data = d; pin_cfg_we = 1'b1;
    @(negedge clk);
    pin_cfg_we = 1'b0;
  endtask

  // pin raised at a negedge; pulses expected after the third posedge
  task automatic pin_fire(input string req, input logic [3:0] es, input logic [3:0] eh);
    @(negedge clk);
    sync_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(req, "start before latency", start_pulse, 4'b0000);
    @(negedge clk);
    check(req, "pin start", start_pulse, es);
    check(req, "pin hop", hop_pulse, eh);
    @(negedge clk);
    check("R9", "pin start one cycle", start_pulse, 4'b0000);
    check("R5", "held pin no repeat hop", hop_pulse, 4'b0000);
    repeat (3) @(negedge clk);
    check("R5", "held pin still quiet", start_pulse | hop_pulse, 4'b0000);
    sync_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_data = '0; sw_we = 1'b0; pin_cfg_we = 1'b0;
    sync_pin = 1'b0; ch_sel = 8'hE4;
    repeat (3) @(negedge clk);
    check("R8", "start in reset", start_pulse, 4'b0000);
    check("R8", "hop in reset", hop_pulse, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "idle after reset", start_pulse | hop_pulse, 4'b0000);

    // software vector table: R1 R2 R3
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ch_sel = VEC[i][23:16];
      wr_data = VEC[i][14:8];
      sw_we = 1'b1;
      @(negedge clk);
      sw_we = 1'b0;
      check("R1", $sformatf("vec%0d start", i), start_pulse, VEC[i][7:4]);
      check("R2", $sformatf("vec%0d hop", i), hop_pulse, VEC[i][3:0]);
      @(negedge clk);
      check("R9", $sformatf("vec%0d one cycle", i), start_pulse | hop_pulse, 4'b0000);
    end

    // R8: pin config zero after reset, pin does nothing
    ch_sel = 8'hE4;
    pin_fire("R8", 4'b0000, 4'b0000);

    // R4: position 0, start and hop
    write_pin_cfg(7'h31);
    pin_fire("R4", 4'b0001, 4'b0001);
    // R4: position 2, start only; R3 shared position
    write_pin_cfg(7'h14);
    pin_fire("R4", 4'b0100, 4'b0000);
    ch_sel = 8'hAA;
    pin_fire("R3", 4'b1111, 4'b0000);
    ch_sel = 8'hE4;

    // R6: first-only
    write_pin_cfg(7'h7F);
    pin_fire("R6", 4'b1111, 4'b1111);
    pin_fire("R6", 4'b0000, 4'b0000);
    write_pin_cfg(7'h7F);
    pin_fire("R6", 4'b1111, 4'b1111);
    write_pin_cfg(7'h3F);
    pin_fire("R6", 4'b1111, 4'b1111);
    pin_fire("R6", 4'b1111, 4'b1111);

    // R7: pin start on pos0 merged with software hop on pos1
    write_pin_cfg(7'h11);
    @(negedge clk);
    sync_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_data = 7'h22; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
    check("R7", "merged start", start_pulse, 4'b0001);
    check("R7", "merged hop", hop_pulse, 4'b0010);
    @(negedge clk);
    check("R9", "merged one cycle", start_pulse | hop_pulse, 4'b0000);
    sync_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R8: reset clears pin config again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pin_fire("R8", 4'b0000, 4'b0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule